// File: doc/BRIEF.md
# Isolated Digital I/O Port with Change Interrupt

This block is the register-mapped core of a digital I/O peripheral with sixteen output lines and sixteen input lines, reached over a simple 8-bit port bus. The bus has a 3-bit offset, a write strobe and a read strobe. The block decodes an eight-byte window. It holds the output drive in two byte latches. It samples the inputs through a two-flop synchronizer.

Any level change on any input line, rising or falling, can raise one shared active-high interrupt request. There is no per-line status, so the host treats every input as a possible source. The controls are access side effects. A read of the control offset turns interrupts on, and a write to it turns them off. A write of any value to the low input offset clears the pending request. That input offset is otherwise read-only.

Read data is combinational. It is valid while the read strobe is high and is 0x00 otherwise. Strobes are sampled on the rising clock edge.

Top module: `dio_port`

## Requirements
- R1: After reset, `dout` is 0x0000, `irq` is low and interrupts are disabled, so input changes do not raise `irq` until the control offset is read.
- R2: A write to offset 0 loads `dout[7:0]` and a write to offset 4 loads `dout[15:8]`. The other byte is unchanged, and the new value is visible one clock after the strobed edge.
- R3: A read of offset 1 returns input lines 7..0, and a read of offset 5 returns input lines 15..8 (bit n of the byte is line n of that byte). The value reflects `din` two clock edges after it changes.
- R4: Reads of offsets 0, 2, 3, 4, 6 and 7 return 0x00. Writes to offsets 3, 5, 6 and 7 leave `dout` and `irq` unchanged.
- R5: A read of offset 2 enables interrupts. A write of any value to offset 2 disables them, and `irq` is low one clock later.
- R6: While interrupts are enabled, a rising or a falling change on any single input line sets the pending flag, and `irq` goes high three clock edges after `din` changes.
- R7: Input changes that arrive while interrupts are disabled do not set the pending flag, and enabling afterwards leaves `irq` low.
- R8: A write of any value to offset 1 clears the pending flag, and `irq` is low one clock later.
- R9: If an input change is detected in the same cycle as a clear write to offset 1, the pending flag stays set and `irq` stays high.
- R10: `irq` is pending AND enabled. A pending flag survives a disable, and `irq` returns as soon as interrupts are enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte offset in the eight-byte window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| din | input | 16 | Asynchronous input lines |
| dout | output | 16 | Latched output drive |
| irq | output | 1 | Active-high interrupt request |

## Verification
The results have different latencies, and each is sampled on the falling edge of the clock where it is due:
- **Output latch:** settles one edge after the write strobe. The bench compares it at the following falling edge.
- **Input reads:** reflect `din` two edges after it changes. The bench therefore waits exactly two rising edges before it strobes a read.
- **Interrupt request:** rises on the third edge after an input change. The bench checks that `irq` is still low after the second edge and high after the third.
- **Edge-versus-clear race:** the bench places the clear strobe on that third edge.
- **Enable and clear:** both act on `irq` one edge after their strobe.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 2;
    localparam int ADDR_W    = 3;

    // Offsets whose behaviour the host depends on
    localparam logic [ADDR_W-1:0] OFS_IRQ_CTL = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_IRQ_CLR = 3'd1;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } bus_req_t;

    // Output byte b lives at 4*b, input byte b at 4*b+1
    function automatic logic [ADDR_W-1:0] out_ofs(input int b);
        return ADDR_W'(4 * b);
    endfunction

    function automatic logic [ADDR_W-1:0] in_ofs(input int b);
        return ADDR_W'(4 * b + 1);
    endfunction

endpackage

// File: rtl/dio_in_sync.sv
module dio_in_sync #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] pins,
    output logic [LINES-1:0] synced,
    output logic             any_edge
);
    logic [LINES-1:0] meta_q, sync_q, prev_q;
    logic [LINES-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pins;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Per-line change detect, both polarities
    for (genvar i = 0; i < LINES; i++) begin : g_edge
        assign diff[i] = sync_q[i] ^ prev_q[i];
    end

    assign synced   = sync_q;
    assign any_edge = |diff;
endmodule

// File: rtl/dio_out_latch.sv
module dio_out_latch
    import dio_pkg::*;
#(
    parameter int BW    = BYTE_W,
    parameter int BYTES = NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    output logic [BW*BYTES-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        logic [BW-1:0] lat_q;
        always_ff @(posedge clk) begin
            if (rst)
                lat_q <= '0;
            else if (req.wr && req.addr == out_ofs(b))
                lat_q <= req.data[BW-1:0];
        end
        assign dout[b*BW +: BW] = lat_q;
    end
endmodule

// File: rtl/dio_irq_ctl.sv
module dio_irq_ctl
    import dio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  logic     any_edge,
    output logic     en,
    output logic     pend,
    output logic     irq
);
    logic en_q, pend_q;
    logic ctl_rd, ctl_wr, clr_wr;

    assign ctl_rd = req.rd && req.addr == OFS_IRQ_CTL;
    assign ctl_wr = req.wr && req.addr == OFS_IRQ_CTL;
    assign clr_wr = req.wr && req.addr == OFS_IRQ_CLR;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (ctl_wr)
            en_q <= 1'b0;
        else if (ctl_rd)
            en_q <= 1'b1;
    end

    // A detected change outranks a clear so no change is lost
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (any_edge && en_q)
            pend_q <= 1'b1;
        else if (clr_wr)
            pend_q <= 1'b0;
    end

    assign en   = en_q;
    assign pend = pend_q;
    assign irq  = pend_q & en_q;
endmodule

// File: rtl/dio_port.sv
module dio_port
    import dio_pkg::*;
#(
    parameter int BW    = BYTE_W,
    parameter int BYTES = NUM_BYTES,
    localparam int LINES = BW * BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BW-1:0]     bus_wdata,
    output logic [BW-1:0]     bus_rdata,
    input  logic [LINES-1:0]  din,
    output logic [LINES-1:0]  dout,
    output logic              irq
);
    bus_req_t         req;
    logic [LINES-1:0] in_sync;
    logic             any_edge;
    logic             irq_en;
    logic             irq_pend;

    always_comb begin
        req      = '0;
        req.wr   = bus_wr;
        req.rd   = bus_rd;
        req.addr = bus_addr;
        req.data = BYTE_W'(bus_wdata);
    end

    dio_in_sync #(.LINES(LINES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pins     (din),
        .synced   (in_sync),
        .any_edge (any_edge)
    );

    dio_out_latch #(.BW(BW), .BYTES(BYTES)) u_out (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .dout (dout)
    );

    dio_irq_ctl u_irq (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .any_edge (any_edge),
        .en       (irq_en),
        .pend     (irq_pend),
        .irq      (irq)
    );

    // Read mux: only the input offsets return data
    logic [BYTES-1:0][BW-1:0] rd_terms;
    for (genvar b = 0; b < BYTES; b++) begin : g_rd
        assign rd_terms[b] = (bus_rd && bus_addr == in_ofs(b))
                           ? in_sync[b*BW +: BW] : '0;
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < BYTES; b++)
            bus_rdata |= rd_terms[b];
    end
endmodule

// File: rtl/dio_port_chk.sv
module dio_port_chk
    import dio_pkg::*;
#(
    parameter int BW    = BYTE_W,
    parameter int LINES = BYTE_W * NUM_BYTES
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BW-1:0]     bus_wdata,
    input logic [LINES-1:0]  dout,
    input logic              irq,
    input logic              en,
    input logic              pend,
    input logic              any_edge
);
    assert_out_lo_load_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0) |=> dout[7:0] == $past(bus_wdata));

    assert_unused_write_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == 3'd5 || bus_addr == 3'd3)) |=> $stable(dout));

    assert_disable_drops_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_IRQ_CTL) |=> !irq && !en);

    assert_enable_on_read_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == OFS_IRQ_CTL) |=> en);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_IRQ_CLR && !any_edge) |=> !pend);

    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_IRQ_CLR && any_edge && en) |=> pend);

    assert_no_pend_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        (!pend && !en) |=> !pend);
endmodule

bind dio_port dio_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .dout      (dout),
    .irq       (irq),
    .en        (irq_en),
    .pend      (irq_pend),
    .any_edge  (any_edge)
);

// File: tb/test_dio_port.sv
module test_dio_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_dout = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dio_port i_dio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .din(din), .dout(dout), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected read data from the bus map
    function automatic logic [7:0] exp_read(input logic [2:0] a, input logic [15:0] lines);
        case (a)
            3'd1:    return lines[7:0];
            3'd5:    return lines[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] exp_write(input logic [2:0] a, input logic [7:0] d,
                                              input logic [15:0] cur);
        logic [15:0] r = cur;
        if (a == 3'd0) r[7:0]  = d;
        if (a == 3'd4) r[15:8] = d;
        return r;
    endfunction

    // All tasks start and end on a falling edge
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'h5EED_1234));
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state, and input change while disabled stays quiet
        check("R1 dout", dout, 16'h0000);
        check("R1 irq", irq, 1'b0);
        din = 16'h0001;
        cycles(4);
        check("R1 irq disabled", irq, 1'b0);

        // R2 directed: byte isolation
        bus_write(3'd0, 8'hA5); exp_dout = 16'h00A5;
        check("R2 low byte", dout, exp_dout);
        bus_write(3'd4, 8'h3C); exp_dout = 16'h3CA5;
        check("R2 high byte", dout, exp_dout);

        // Random mix of writes and reads (interrupts disabled)
        for (int i = 0; i < 200; i++) begin
            int op = $urandom_range(0, 3);
            logic [2:0] a;
            logic [7:0] d = 8'($urandom);
            if (op == 0) begin
                a = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'd4;
                bus_write(a, d); exp_dout = exp_write(a, d, exp_dout);
                check("R2 random write", dout, exp_dout);
            end else if (op == 1) begin
                logic [2:0] pick [4] = '{3'd3, 3'd5, 3'd6, 3'd7};
                a = pick[$urandom_range(0, 3)];
                bus_write(a, d);
                check("R4 ignored write", dout, exp_dout);
                check("R4 irq quiet", irq, 1'b0);
            end else if (op == 2) begin
                din = 16'($urandom);
                cycles(2);
                a = ($urandom_range(0, 1) == 0) ? 3'd1 : 3'd5;
                bus_read(a, rd);
                check("R3 input read", rd, exp_read(a, din));
            end else begin
                logic [2:0] pick [5] = '{3'd0, 3'd3, 3'd4, 3'd6, 3'd7};
                a = pick[$urandom_range(0, 4)];
                bus_read(a, rd);
                check("R4 zero read", rd, 8'h00);
            end
        end

        // R3 latency: after only one edge the old value still shows
        din = 16'h0000; cycles(3);
        din = 16'h8001;
        cycles(1);
        bus_read(3'd5, rd);
        check("R3 not yet", rd, 8'h00);
        bus_read(3'd5, rd);
        check("R3 high byte", rd, 8'h80);

        // R7: changes while disabled, then enable: no irq
        din = 16'h00F0; cycles(4);
        bus_read(3'd2, rd);
        check("R4 ctl read zero", rd, 8'h00);
        check("R7 no stale pending", irq, 1'b0);

        // R6 rising edge on line 9: timing
        din[9] = 1'b1;
        cycles(2);
        check("R6 not before third edge", irq, 1'b0);
        cycles(1);
        check("R6 rising", irq, 1'b1);

        // R8: clear with arbitrary data
        bus_write(3'd1, 8'h5A);
        check("R8 clear", irq, 1'b0);

        // R6 falling edge on line 4
        din[4] = 1'b0;
        cycles(3);
        check("R6 falling", irq, 1'b1);
        bus_write(3'd1, 8'h00);
        check("R8 clear zero data", irq, 1'b0);

        // R9: clear strobe on the same edge as detection
        din[15] = 1'b1;
        cycles(2);
        bus_write(3'd1, 8'hFF);
        check("R9 edge wins", irq, 1'b1);
        bus_write(3'd1, 8'hFF);
        check("R9 later clear", irq, 1'b0);

        // R5 / R10: disable hides, re-enable reveals pending
        din[0] = 1'b1;
        cycles(3);
        check("R10 irq set", irq, 1'b1);
        bus_write(3'd2, 8'h00);
        check("R5 disable", irq, 1'b0);
        bus_read(3'd2, rd);
        check("R10 pending kept", irq, 1'b1);
        bus_write(3'd1, 8'h00);
        check("R10 cleared", irq, 1'b0);

        // R4: write to input-high offset changes nothing
        bus_write(3'd5, 8'hFF);
        check("R4 off5 dout", dout, exp_dout);
        check("R4 off5 irq", irq, 1'b0);

        finish_run();
    end
endmodule